// File: doc/BRIEF.md
# Carry-free redundant decimal adder

This block adds two multi-digit radix-10 numbers held in a redundant digit format. Each digit is a 5-bit field that may carry any value from 0 to 18, so a single number has many encodings. Because of that slack, no position ever has to wait for a carry that ripples up from far below. Each position needs only the operand digits of its own position and a small transfer from the position just beneath it.

Every position works on its own. It adds its two operand digits, then splits the raw sum into a transfer of 0, 1 or 2 and an interim digit. The interim digit is then added to the transfer arriving from the position below. The result uses the same redundant format and has one extra top digit. The number of digits is a parameter. The logic depth of the adder is the same for any operand length, and an optional register stage makes the result available one clock after the operands.

Top module: `rda_adder`

## Requirements
- R1: Operand digit i lives at bits [5i+4:5i] of its port, has weight 10^i, and takes values 0 to 18. Result digit j lives at bits [5j+4:5j] of `sum_o`, for j from 0 to NDIG.
- R2: In each position the two operand digits form a raw sum from 0 to 36.
- R3: The transfer of a position is 0 when the raw sum is 0 to 16, 1 when it is 17 to 26, and 2 when it is 27 to 36. The interim digit is the raw sum minus ten times the transfer, so it lies in 0 to 16.
- R4: Result digit i (i < NDIG) is interim digit i plus the transfer of position i-1. Position 0 receives a transfer of zero, so result digit 0 equals interim digit 0.
- R5: Every result digit 0 to NDIG-1 stays in 0 to 18.
- R6: Result digit NDIG equals the transfer of position NDIG-1, so it lies in 0 to 2.
- R7: The value of the result, with each digit weighted by a power of ten, equals the sum of the values of the two operands.
- R8: With REG_OUT=1, the result for the operands present at a rising clock edge appears just after that edge. The result keeps its old value until that edge. The delay is the same for every operand pattern, including patterns where every position produces a transfer.
- R9: With REG_OUT=1, a synchronous active-high `rst` clears `sum_o` to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opa_i | input | 5*NDIG | First operand, redundant decimal digits |
| opb_i | input | 5*NDIG | Second operand, redundant decimal digits |
| sum_o | output | 5*(NDIG+1) | Sum, redundant decimal digits plus one top digit |

## Verification
The assertions take for granted that every operand digit is a legal redundant digit (0 to 18). A 5-bit field could hold 19 to 31, and such a value would break the range and value properties. The stimulus therefore builds every operand from digits drawn only from 0 to 18. It uses directed raw-sum sweeps, all-maximum and top-position patterns, and random digits restricted to that range.

// File: rtl/rda_pkg.sv
package rda_pkg;
  // Digit format of the redundant decimal number system
  localparam int DIG_W    = 5;
  localparam int RAW_W    = DIG_W + 1;
  localparam int XFER_W   = 2;
  localparam int RADIX    = 10;
  localparam int DIG_MAX  = 18;
  // Raw-sum thresholds that select the transfer
  localparam int XFER1_MIN = 17;
  localparam int XFER2_MIN = 27;

  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [RAW_W-1:0]  raw_t;
  typedef logic [XFER_W-1:0] xfer_t;
endpackage

// File: rtl/rda_split.sv
// One position: raw sum of two digits, split into transfer and interim digit.
module rda_split
  import rda_pkg::*;
(
  input  digit_t a_i,
  input  digit_t b_i,
  output xfer_t  xfer_o,
  output digit_t interim_o
);
  raw_t raw;

  assign raw = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (raw >= RAW_W'(XFER2_MIN)) begin
      xfer_o    = 2'd2;
      interim_o = raw[DIG_W-1:0] - DIG_W'(2 * RADIX);
    end else if (raw >= RAW_W'(XFER1_MIN)) begin
      xfer_o    = 2'd1;
      interim_o = raw[DIG_W-1:0] - DIG_W'(RADIX);
    end else begin
      xfer_o    = 2'd0;
      interim_o = raw[DIG_W-1:0];
    end
  end
endmodule

// File: rtl/rda_merge.sv
// One position: interim digit plus the transfer from the position below.
module rda_merge
  import rda_pkg::*;
(
  input  digit_t interim_i,
  input  xfer_t  xfer_i,
  output digit_t digit_o
);
  assign digit_o = interim_i + {{(DIG_W-XFER_W){1'b0}}, xfer_i};
endmodule

// File: rtl/rda_out_stage.sv
// Optional output register, chosen by a parameter.
module rda_out_stage #(
  parameter int W       = 45,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
      end
    end else begin : g_comb
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/rda_adder.sv
// Carry-free redundant decimal adder top.
module rda_adder
  import rda_pkg::*;
#(
  parameter int NDIG    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DIG_W*NDIG-1:0]     opa_i,
  input  logic [DIG_W*NDIG-1:0]     opb_i,
  output logic [DIG_W*(NDIG+1)-1:0] sum_o
);
  localparam int OPW  = DIG_W * NDIG;
  localparam int SUMW = DIG_W * (NDIG + 1);

  logic [XFER_W*NDIG-1:0] xfer_flat;
  logic [OPW-1:0]         interim_flat;
  logic [SUMW-1:0]        sum_comb;

  genvar i;
  generate
    for (i = 0; i < NDIG; i++) begin : g_pos
      xfer_t xfer_in;

      rda_split u_split (
        .a_i       (opa_i[DIG_W*i +: DIG_W]),
        .b_i       (opb_i[DIG_W*i +: DIG_W]),
        .xfer_o    (xfer_flat[XFER_W*i +: XFER_W]),
        .interim_o (interim_flat[DIG_W*i +: DIG_W])
      );

      if (i == 0) begin : g_lsd
        assign xfer_in = '0;
      end else begin : g_upper
        assign xfer_in = xfer_flat[XFER_W*(i-1) +: XFER_W];
      end

      rda_merge u_merge (
        .interim_i (interim_flat[DIG_W*i +: DIG_W]),
        .xfer_i    (xfer_in),
        .digit_o   (sum_comb[DIG_W*i +: DIG_W])
      );
    end
  endgenerate

  // Transfer out of the top position becomes the extra top digit
  assign sum_comb[DIG_W*NDIG +: DIG_W] =
    {{(DIG_W-XFER_W){1'b0}}, xfer_flat[XFER_W*(NDIG-1) +: XFER_W]};

  rda_out_stage #(.W(SUMW), .REG_OUT(REG_OUT)) u_out (
    .clk (clk),
    .rst (rst),
    .d_i (sum_comb),
    .q_o (sum_o)
  );
endmodule

// File: rtl/rda_adder_chk.sv
module rda_adder_chk
  import rda_pkg::*;
#(
  parameter int NDIG    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [DIG_W*NDIG-1:0]     opa_i,
  input logic [DIG_W*NDIG-1:0]     opb_i,
  input logic [DIG_W*(NDIG+1)-1:0] sum_o,
  input logic [XFER_W*NDIG-1:0]    xfer_flat,
  input logic [DIG_W*NDIG-1:0]     interim_flat
);
  function automatic longint unsigned op_value(input logic [DIG_W*NDIG-1:0] v);
    longint unsigned acc = 0;
    for (int k = NDIG - 1; k >= 0; k--)
      acc = acc * RADIX + longint'(v[DIG_W*k +: DIG_W]);
    return acc;
  endfunction

  function automatic longint unsigned sum_value(input logic [DIG_W*(NDIG+1)-1:0] v);
    longint unsigned acc = 0;
    for (int k = NDIG; k >= 0; k--)
      acc = acc * RADIX + longint'(v[DIG_W*k +: DIG_W]);
    return acc;
  endfunction

  genvar i;
  generate
    for (i = 0; i < NDIG; i++) begin : g_dig
      // R3
      xfer_range_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_flat[XFER_W*i +: XFER_W] <= 2'd2);
      // R3
      interim_range_chk: assert property (@(posedge clk) disable iff (rst)
        interim_flat[DIG_W*i +: DIG_W] <= DIG_W'(DIG_MAX - 2));
      // R5
      digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        sum_o[DIG_W*i +: DIG_W] <= DIG_W'(DIG_MAX));
    end

    // R6
    top_digit_chk: assert property (@(posedge clk) disable iff (rst)
      sum_o[DIG_W*NDIG +: DIG_W] <= DIG_W'(2));

    if (REG_OUT) begin : g_reg_chk
      // R7
      exact_sum_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sum_value(sum_o) == $past(op_value(opa_i) + op_value(opb_i)));
      // R9
      reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> sum_o == '0);
    end else begin : g_comb_chk
      // R7
      exact_sum_chk: assert property (@(posedge clk) disable iff (rst)
        sum_value(sum_o) == op_value(opa_i) + op_value(opb_i));
    end
  endgenerate
endmodule

bind rda_adder rda_adder_chk #(.NDIG(NDIG), .REG_OUT(REG_OUT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .opa_i        (opa_i),
  .opb_i        (opb_i),
  .sum_o        (sum_o),
  .xfer_flat    (xfer_flat),
  .interim_flat (interim_flat)
);

// File: tb/rda_adder_bench.sv
`timescale 1ns/100ps
module rda_adder_bench;
  localparam int NDIG = 8;
  localparam int DW   = 5;
  localparam int OPW  = DW * NDIG;
  localparam int SW   = DW * (NDIG + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [OPW-1:0] opa = '0;
  logic [OPW-1:0] opb = '0;
  logic [SW-1:0]  sum;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  rda_adder #(.NDIG(NDIG), .REG_OUT(1'b1)) u_rda_adder (
    .clk   (clk),
    .rst   (rst),
    .opa_i (opa),
    .opb_i (opb),
    .sum_o (sum)
  );

  function automatic longint unsigned opval(input logic [OPW-1:0] v);
    longint unsigned acc = 0;
    for (int k = NDIG - 1; k >= 0; k--) acc = acc * 10 + longint'(v[DW*k +: DW]);
    return acc;
  endfunction

  function automatic longint unsigned sumval(input logic [SW-1:0] v);
    longint unsigned acc = 0;
    for (int k = NDIG; k >= 0; k--) acc = acc * 10 + longint'(v[DW*k +: DW]);
    return acc;
  endfunction

  // Expected result digits built from the threshold rule (R3, R4, R6)
  function automatic logic [SW-1:0] expect_vec(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic [SW-1:0] r = '0;
    int tin = 0;
    for (int k = 0; k < NDIG; k++) begin
      int raw = int'(a[DW*k +: DW]) + int'(b[DW*k +: DW]);
      int t = (raw >= 27) ? 2 : (raw >= 17) ? 1 : 0;
      r[DW*k +: DW] = DW'(raw - 10 * t + tin);
      tin = t;
    end
    r[DW*NDIG +: DW] = DW'(tin);
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [SW-1:0] got, input logic [SW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_num(input string tag, input longint unsigned got, input longint unsigned exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_range(input string tag, input logic [SW-1:0] v);
    int worst = 0;
    for (int k = 0; k < NDIG; k++)
      if (int'(v[DW*k +: DW]) > worst) worst = int'(v[DW*k +: DW]);
    total++;
    if (worst > 18 || int'(v[DW*NDIG +: DW]) > 2) begin
      bad++;
      $display("FAIL %s: max digit %0d top %0d expected <=18 and <=2",
               tag, worst, v[DW*NDIG +: DW]);
    end
  endtask

  // Drive operands away from the edge, sample just after the next edge
  task automatic apply(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    @(negedge clk);
    opa = a;
    opb = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    opa = {NDIG{5'd18}};
    opb = {NDIG{5'd18}};
    @(posedge clk);
    #1;
    check_vec("R9 reset clears sum", sum, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_zero;
    apply('0, '0);
    check_vec("R4 zero plus zero", sum, '0);
  endtask

  // Every raw sum 0..36 at a moving position (R2, R3, R4, R6)
  task automatic t_raw_sweep;
    for (int raw = 0; raw <= 36; raw++) begin
      logic [OPW-1:0] a = '0;
      logic [OPW-1:0] b = '0;
      int pos = raw % NDIG;
      int da = (raw > 18) ? 18 : raw;
      a[DW*pos +: DW] = DW'(da);
      b[DW*pos +: DW] = DW'(raw - da);
      apply(a, b);
      check_vec($sformatf("R3 raw sweep raw=%0d pos=%0d", raw, pos), sum, expect_vec(a, b));
    end
  endtask

  // Threshold edges checked digit by digit in position 0 (R3, R4)
  task automatic t_thresholds;
    int raws[6] = '{16, 17, 26, 27, 36, 0};
    int exp_lo[6] = '{16, 7, 16, 7, 16, 0};
    int exp_t[6]  = '{0, 1, 1, 2, 2, 0};
    for (int n = 0; n < 6; n++) begin
      logic [OPW-1:0] a = '0;
      logic [OPW-1:0] b = '0;
      int da = (raws[n] > 18) ? 18 : raws[n];
      a[DW-1:0] = DW'(da);
      b[DW-1:0] = DW'(raws[n] - da);
      apply(a, b);
      check_num($sformatf("R4 digit0 raw=%0d", raws[n]), longint'(sum[DW-1:0]), longint'(exp_lo[n]));
      check_num($sformatf("R3 transfer raw=%0d", raws[n]), longint'(sum[DW +: DW]), longint'(exp_t[n]));
    end
  endtask

  // All digits at 18: every position transfers (R5, R6, R7, R8)
  task automatic t_all_max;
    logic [SW-1:0] exp = '0;
    apply({NDIG{5'd18}}, {NDIG{5'd18}});
    exp[DW-1:0] = 5'd16;
    for (int k = 1; k < NDIG; k++) exp[DW*k +: DW] = 5'd18;
    exp[DW*NDIG +: DW] = 5'd2;
    check_vec("R5 all-max digits", sum, exp);
    check_num("R7 all-max value", sumval(sum), opval({NDIG{5'd18}}) * 2);
    check_range("R5 all-max range", sum);
  endtask

  // Only the top position is loaded: transfer becomes extra digit (R6)
  task automatic t_top;
    logic [OPW-1:0] a = '0;
    logic [OPW-1:0] b = '0;
    a[DW*(NDIG-1) +: DW] = 5'd18;
    b[DW*(NDIG-1) +: DW] = 5'd9;
    apply(a, b);
    check_num("R6 top digit", longint'(sum[DW*NDIG +: DW]), 2);
    check_num("R6 digit below top", longint'(sum[DW*(NDIG-1) +: DW]), 7);
  endtask

  // Result holds until the edge, then updates in one cycle (R8)
  task automatic t_latency;
    logic [SW-1:0] old_v;
    apply({NDIG{5'd1}}, {NDIG{5'd2}});
    old_v = sum;
    @(negedge clk);
    opa = {NDIG{5'd17}};
    opb = {NDIG{5'd13}};
    #1;
    check_vec("R8 holds before edge", sum, old_v);
    @(posedge clk);
    #1;
    check_vec("R8 one-cycle update", sum, expect_vec({NDIG{5'd17}}, {NDIG{5'd13}}));
  endtask

  // Random legal digits (R1, R5, R7)
  task automatic t_random(input int n);
    for (int it = 0; it < n; it++) begin
      logic [OPW-1:0] a;
      logic [OPW-1:0] b;
      for (int k = 0; k < NDIG; k++) begin
        a[DW*k +: DW] = DW'($urandom_range(0, 18));
        b[DW*k +: DW] = DW'($urandom_range(0, 18));
      end
      apply(a, b);
      check_num($sformatf("R7 random value #%0d", it), sumval(sum), opval(a) + opval(b));
      check_range($sformatf("R5 random range #%0d", it), sum);
      check_vec($sformatf("R1 random digits #%0d", it), sum, expect_vec(a, b));
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_zero();
    t_raw_sweep();
    t_thresholds();
    t_all_max();
    t_top();
    t_latency();
    t_random(300);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule